// File: doc/BRIEF.md
# Programmable Configuration Clock Burst Generator

This block sits beside a configuration sequencer and issues a programmed number of clock pulses on a dedicated configuration clock line once the data stream has ended. Software, or the sequencer, writes the wanted pulse count into a count register on a simple single-cycle register bus. That write alone starts the burst. No separate start bit exists. Each pulse is one clock cycle high followed by one clock cycle low. When the last low phase ends, a sticky completion flag sets. The flag appears on the status register and on a dedicated output, and it stays set until it is cleared by writing a one to it.

A state machine with three states controls the block. ST_IDLE holds the pulse line low. ST_HIGH drives the pulse line high and uses up one pulse from the remaining count. ST_LOW drives the line low and then either returns to ST_HIGH or ends the burst. The transitions are:
- START: from ST_IDLE to ST_HIGH, on a nonzero count write.
- PHASE: from ST_HIGH to ST_LOW.
- NEXT: from ST_LOW to ST_HIGH, while pulses remain.
- FINISH: from ST_LOW to ST_IDLE, which sets the flag.
- RESTART: from any state to ST_HIGH, on a nonzero count write.
- ABORT: from any state to ST_IDLE, on a zero count write.

Reading the count register returns the number of pulses that have not yet been emitted. A burst of four pulses takes eight clock cycles.

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset the pulse output is low, the done output is 0, and reads of the count register (offset 0x8) and the status register (offset 0xC) return 0.
- R2: A bus write to offset 0x8 with nonzero N in data bits [CNT_W-1:0] starts a burst of exactly N pulses. Data bits above CNT_W are ignored. The output is high in the first cycle after the write edge, and each pulse is one cycle high followed by one cycle low.
- R3: The done flag (status bit 0) sets at the clock edge that ends the last low phase, which is exactly 2N edges after the write edge. It then stays set until it is cleared.
- R4: Writing offset 0xC with data bit 0 = 1 clears the done flag, and writing it with bit 0 = 0 has no effect. If a clear arrives on the same edge at which the flag sets, the set wins.
- R5: A nonzero count write during a burst restarts the burst with the new count. Any nonzero count write clears the done flag.
- R6: A count write of 0 produces no pulses and leaves the done flag unchanged. It also ends any burst in progress, so that the count then reads 0.
- R7: A read of offset 0x8 returns the pulses not yet emitted: N in the first high cycle, with one subtracted at the end of each high phase. A read of offset 0xC returns the done flag in bit 0 and 0 in the other bits. A read of any other offset returns 0.
- R8: The pulse output stays low whenever no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset for the read or the write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| clk_pulse_o | output | 1 | Configuration clock pulse line |
| burst_done_o | output | 1 | Sticky burst-complete flag |

## Verification
The hardest case to reach from the ports is the single edge at which FINISH sets the flag while a status clear is captured on that same edge. The stimulus gets there with a one-pulse burst, an idle cycle, and then a status write, so that the clear lands exactly on the second edge after the count write. Restart and abort are reached by writing the count register a few cycles into a running burst. The scoreboard then drops the truncated burst and checks the pulse pattern of the new count cycle by cycle.

// File: rtl/pbg_pkg.sv
`timescale 1ns/1ps
package pbg_pkg;
    // Burst sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } burst_state_e;
endpackage

// File: rtl/pbg_regs.sv
`timescale 1ns/1ps
module pbg_regs #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 'h8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'hC
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  remaining,
    input  logic              done,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              clr_req
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic hit_cnt;
    logic hit_stat;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    always_comb begin
        hit_cnt  = (bus_addr == CNT_OFS);
        hit_stat = (bus_addr == STAT_OFS);
    end

    // Write decode: a count write is the start command
    always_comb begin
        load     = bus_wr && hit_cnt;
        load_val = bus_wdata[CNT_W-1:0];
        clr_req  = bus_wr && hit_stat && bus_wdata[0];
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_cnt) begin
            bus_rdata = {{PAD_W{1'b0}}, remaining};
        end else if (hit_stat) begin
            bus_rdata[0] = done;
        end
    end
endmodule

// File: rtl/pbg_seq.sv
`timescale 1ns/1ps
module pbg_seq
    import pbg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_req,
    output logic             pulse,
    output logic             done,
    output logic [CNT_W-1:0] remaining,
    output logic             busy
);
    burst_state_e state_q;
    burst_state_e state_nx;
    logic [CNT_W-1:0] rem_q;
    logic load_nz;
    logic finish;

    always_comb begin
        load_nz = |load_val;
        finish  = (state_q == ST_LOW) && (rem_q == '0) && !load;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load && load_nz) state_nx = ST_HIGH;          // START
            end
            ST_HIGH: begin
                if (load)            state_nx = load_nz ? ST_HIGH : ST_IDLE; // RESTART / ABORT
                else                 state_nx = ST_LOW;           // PHASE
            end
            ST_LOW: begin
                if (load)            state_nx = load_nz ? ST_HIGH : ST_IDLE; // RESTART / ABORT
                else if (rem_q == '0) state_nx = ST_IDLE;         // FINISH
                else                 state_nx = ST_HIGH;          // NEXT
            end
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // Remaining pulse count: consumed at the end of each high phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (state_q == ST_HIGH) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Sticky completion flag: set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
        end else if (load && load_nz) begin
            done <= 1'b0;
        end else if (clr_req) begin
            done <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        pulse     = (state_q == ST_HIGH);
        busy      = (state_q != ST_IDLE);
        remaining = rem_q;
    end
endmodule

// File: rtl/pulse_burst_gen.sv
`timescale 1ns/1ps
module pulse_burst_gen #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 'h8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_pulse_o,
    output logic              burst_done_o
);
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             clr;
    logic [CNT_W-1:0] rem_cnt;
    logic             seq_busy;
    logic             seq_done;
    logic             seq_pulse;

    pbg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .CNT_OFS(CNT_OFS), .STAT_OFS(STAT_OFS)
    ) u_regs (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .remaining (rem_cnt),
        .done      (seq_done),
        .bus_rdata (bus_rdata),
        .load      (ld),
        .load_val  (ld_val),
        .clr_req   (clr)
    );

    pbg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_val  (ld_val),
        .clr_req   (clr),
        .pulse     (seq_pulse),
        .done      (seq_done),
        .remaining (rem_cnt),
        .busy      (seq_busy)
    );

    assign clk_pulse_o  = seq_pulse;
    assign burst_done_o = seq_done;
endmodule

// File: rtl/pbg_checker.sv
`timescale 1ns/1ps
module pbg_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter logic [ADDR_W-1:0] CNT_OFS  = 'h8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'hC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              clk_pulse_o,
    input logic              burst_done_o,
    input logic [CNT_W-1:0]  remaining,
    input logic              busy
);
    logic cnt_wr;
    logic stat_wr;
    logic cnt_nz;
    logic unused_chk_hi;

    assign unused_chk_hi = ^bus_wdata[DATA_W-1:CNT_W];
    assign cnt_wr  = bus_wr && (bus_addr == CNT_OFS);
    assign stat_wr = bus_wr && (bus_addr == STAT_OFS);
    assign cnt_nz  = |bus_wdata[CNT_W-1:0];

    a_r2_one_cycle_high: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pulse_o && !cnt_wr |=> !clk_pulse_o);

    a_r2_start_burst: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && cnt_nz |=> clk_pulse_o && (remaining == $past(bus_wdata[CNT_W-1:0])));

    a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done_o && !bus_wr |=> burst_done_o);

    a_r4_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && bus_wdata[0] && !busy |=> !burst_done_o);

    a_r4_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && !bus_wdata[0] && !busy |=> $stable(burst_done_o));

    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && cnt_nz |=> !burst_done_o);

    a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr && !cnt_nz |=> !clk_pulse_o && !busy && $stable(burst_done_o));

    a_r7_count_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> remaining <= $past(remaining));
endmodule

bind pulse_burst_gen pbg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CNT_OFS(CNT_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .clk_pulse_o  (clk_pulse_o),
    .burst_done_o (burst_done_o),
    .remaining    (rem_cnt),
    .busy         (seq_busy)
);

// File: tb/sim_pulse_burst_gen.sv
`timescale 1ns/1ps
module sim_pulse_burst_gen;
    localparam logic [11:0] CNT_A  = 12'h008;
    localparam logic [11:0] STAT_A = 12'h00C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pulse;
    logic        done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    bit mon_on = 0;
    int exp_q[$];

    // Monitor state
    int  cyc = 0;
    int  cur_n = 0;
    int  cur_w = 0;
    int  pulses = 0;
    bit  act = 0;

    pulse_burst_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .clk_pulse_o  (pulse),
        .burst_done_o (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bidle();
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Driver: pushes the expected pulse count, then issues the count write
    task automatic start_count(input logic [31:0] raw, input int exp_n);
        exp_q.push_back(exp_n);
        bwrite(CNT_A, raw);
        bidle();
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (bus_wr && bus_addr == CNT_A) begin
                if (exp_q.size() > 0) cur_n = exp_q.pop_front();
                else cur_n = 0;
                cur_w  = cyc;
                pulses = 0;
                act    = (cur_n != 0);
            end else if (act) begin
                int k;
                k = cyc - cur_w;
                if (k <= 2 * cur_n) begin
                    check(pulse == ((k % 2) == 1), "R2", pulse, (k % 2) == 1);
                    check(done == 1'b0, "R5", done, 0);
                    if (pulse) pulses++;
                end else begin
                    check(done == 1'b1, "R3", done, 1);
                    check(pulses == cur_n, "R2", pulses, cur_n);
                    check(pulse == 1'b0, "R8", pulse, 0);
                    act = 0;
                end
            end else begin
                check(pulse == 1'b0, "R8", pulse, 0);
            end
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(pulse == 1'b0, "R1", pulse, 0);
        check(done == 1'b0, "R1", done, 0);
        bread(CNT_A, rd);  check(rd == 0, "R1", rd, 0);
        bread(STAT_A, rd); check(rd == 0, "R1", rd, 0);
        mon_on = 1;

        // Four-pulse burst
        start_count(32'd4, 4);
        wait_neg(12);
        check(done == 1'b1, "R3", done, 1);

        // Status write semantics
        bread(STAT_A, rd); check(rd == 1, "R7", rd, 1);
        bwrite(STAT_A, 32'h0); bidle();
        bread(STAT_A, rd); check(rd == 1, "R4", rd, 1);
        bwrite(STAT_A, 32'h1); bidle();
        bread(STAT_A, rd); check(rd == 0, "R4", rd, 0);
        check(done == 1'b0, "R4", done, 0);

        // Remaining-count readback (bus_addr stays at the count offset)
        start_count(32'd6, 6);
        @(negedge clk); check(bus_rdata == 6, "R7", bus_rdata, 6);
        @(negedge clk); check(bus_rdata == 5, "R7", bus_rdata, 5);
        @(negedge clk); check(bus_rdata == 5, "R7", bus_rdata, 5);
        @(negedge clk); check(bus_rdata == 4, "R7", bus_rdata, 4);
        wait_neg(12);
        check(done == 1'b1, "R3", done, 1);

        // Restart mid-burst with done already set
        start_count(32'd5, 5);
        wait_neg(2);
        start_count(32'd3, 3);
        wait_neg(10);
        check(done == 1'b1, "R5", done, 1);

        // Zero count while idle leaves done alone
        start_count(32'd0, 0);
        wait_neg(6);
        check(done == 1'b1, "R6", done, 1);
        bread(CNT_A, rd); check(rd == 0, "R6", rd, 0);

        // Clear colliding with the finishing edge: set wins
        bwrite(STAT_A, 32'h1); bidle();
        start_count(32'd1, 1);
        bwrite(STAT_A, 32'h1); bidle();
        wait_neg(3);
        check(done == 1'b1, "R4", done, 1);

        // Abort a running burst with a zero count
        bwrite(STAT_A, 32'h1); bidle();
        start_count(32'd10, 10);
        wait_neg(4);
        start_count(32'd0, 0);
        wait_neg(30);
        check(done == 1'b0, "R6", done, 0);
        bread(CNT_A, rd); check(rd == 0, "R6", rd, 0);

        // Upper data bits ignored
        start_count(32'h0003_0002, 2);
        wait_neg(8);
        check(done == 1'b1, "R2", done, 1);

        // Unmapped offsets read zero
        bread(12'h000, rd); check(rd == 0, "R7", rd, 0);
        bread(12'h010, rd); check(rd == 0, "R7", rd, 0);
        bread(STAT_A, rd);  check(rd == 1, "R7", rd, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule